// File: doc/BRIEF.md
# Camera Parallel Input Front-End

This block takes the byte-wide output of an image sensor and turns it into a stream of cropped 4:2:2 pixel pairs. The sensor's pixel clock arrives as a slow input that the block samples with its own fast clock. Bytes are taken on the pixel-clock edge that configuration selects. Frame and line timing come from one of two sources. In the first, separate horizontal and vertical sync pins carry it, each with its own polarity. In the second, four-byte sync codes embedded in the data carry it.

Each four-byte group is reordered from any of four sensor byte orders into a fixed luma/chroma layout. Only groups that fall inside a programmable crop window leave the block. Each pair carries start-of-frame, end-of-frame and field flags. The output is a valid/ready stream with one holding register. The sensor cannot be stalled, so a pair that arrives while the holding register is still full is discarded. The held pair stays unchanged until the consumer accepts it.

Capture starts only at a frame boundary. An optional one-shot mode stops capture after the first complete frame.

Top module: `cam_frontend`

## Requirements
- R1: While reset is asserted and right after it, out_valid, frame_done and capturing are 0.
- R2: A byte, together with the sync pin levels, is taken only on the pixel-clock edge selected by cfg_pclk_rise (1 = rising, 0 = falling). Values present on the other edge are ignored.
- R3: With cfg_embedded = 0, sync pins are active when they equal cfg_hs_high / cfg_vs_high. A byte is active video when hsync is active and vsync is inactive. A frame begins on the first byte taken after vsync turns inactive.
- R4: With cfg_embedded = 1, the pins are ignored and timing comes from codes FF 00 00 XY. In XY, bit 6 is the field, bit 5 is vertical blanking and bit 4 is end-of-line. Active video is every byte after a code with bits 5 and 4 clear, up to the next FF byte. A frame begins at the first such code that follows a code with bit 5 set.
- R5: Within each line, bytes form groups of four from the first active byte. cfg_order gives the arrival order: 0 = Y0 U Y1 V, 1 = Y0 V Y1 U, 2 = U Y0 V Y1, 3 = V Y0 U Y1.
- R6: A group covers pixels x and x+1, where x = 0, 2, 4 and so on within the line. Lines count from 0 at the start of the frame. A group is emitted only if crop_x0 <= x < crop_x0 + crop_w and crop_y0 <= line < crop_y0 + crop_h. crop_x0 and crop_w are even.
- R7: out_sof is set on the pair at (crop_x0, crop_y0). out_eof is set on the pair at (crop_x0 + crop_w - 2, crop_y0 + crop_h - 1). No other pair carries either flag.
- R8: out_field is 0 in separate-sync mode. In embedded mode it is the XY field bit of the last code. If cfg_fbb is set, the field instead toggles at each frame start, and the first such frame after reset is field 0.
- R9: capturing is loaded from cap_enable at each frame start, so a frame is either taken whole or not at all. Pairs leave only while capturing is 1.
- R10: frame_done pulses for one cycle when the end-of-frame pair is produced during capture. If cap_oneshot is 1, capturing drops at that moment and stays 0 until cap_enable has been low.
- R11: While out_valid is 1 and out_ready is 0, out_pair and its flags hold steady. Pairs produced meanwhile are dropped.
- R12: out_pair packs Y0 in bits 7:0, U in bits 15:8, Y1 in bits 23:16 and V in bits 31:24.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pclk | input | 1 | Sensor pixel clock, sampled |
| hsync | input | 1 | Sensor horizontal sync pin |
| vsync | input | 1 | Sensor vertical sync pin |
| pix_data | input | 8 | Sensor data byte |
| cap_enable | input | 1 | Request capture from the next frame |
| cap_oneshot | input | 1 | Stop after one captured frame |
| cfg_embedded | input | 1 | 1 = timing from embedded codes |
| cfg_fbb | input | 1 | Field from frame toggling in embedded mode |
| cfg_order | input | 2 | Sensor byte order |
| cfg_pclk_rise | input | 1 | 1 = latch on rising pixel-clock edge |
| cfg_hs_high | input | 1 | hsync active level |
| cfg_vs_high | input | 1 | vsync active level |
| crop_x0 | input | 12 | Crop start column (pixels, even) |
| crop_y0 | input | 11 | Crop start line |
| crop_w | input | 12 | Crop width (pixels, even) |
| crop_h | input | 11 | Crop height (lines) |
| out_valid | output | 1 | Pair available |
| out_ready | input | 1 | Consumer accepts pair |
| out_pair | output | 32 | Packed Y0, U, Y1, V |
| out_sof | output | 1 | First pair of the window |
| out_eof | output | 1 | Last pair of the window |
| out_field | output | 1 | Field of the frame |
| frame_done | output | 1 | One-cycle end-of-window pulse |
| capturing | output | 1 | Capture active for the current frame |

## Verification
The assertions assume the following about the inputs. Each pixel-clock level lasts at least two system clocks, so no edge is missed. Data and sync pins are stable on the latching edge. Configuration changes only between frames. Embedded-mode video never contains the byte FF.

The stimulus holds each pixel-clock phase for two cycles and keeps pixel values below 0x80. It puts a decoy byte on the non-latching edge. It changes settings only while the sensor is blanked. The one exception is out_ready, which it holds low across a whole frame to exercise the holding rules.

// File: rtl/cam_pkg.sv
package cam_pkg;
  localparam int PIX_W  = 8;
  localparam int PAIR_W = 4 * PIX_W;

  localparam logic [PIX_W-1:0] SYNC_LEAD = 8'hFF;
  localparam logic [PIX_W-1:0] SYNC_ZERO = 8'h00;
  localparam int XY_FIELD = 6;
  localparam int XY_VBLK  = 5;
  localparam int XY_EOL   = 4;

  typedef enum logic [1:0] {
    ORD_Y_U_Y_V = 2'd0,
    ORD_Y_V_Y_U = 2'd1,
    ORD_U_Y_V_Y = 2'd2,
    ORD_V_Y_U_Y = 2'd3
  } byte_order_e;

  typedef struct packed {
    logic [PIX_W-1:0] v;
    logic [PIX_W-1:0] y1;
    logic [PIX_W-1:0] u;
    logic [PIX_W-1:0] y0;
  } pair_t;

  function automatic pair_t reorder(input byte_order_e o,
                                    input logic [PIX_W-1:0] b0,
                                    input logic [PIX_W-1:0] b1,
                                    input logic [PIX_W-1:0] b2,
                                    input logic [PIX_W-1:0] b3);
    pair_t p;
    case (o)
      ORD_Y_U_Y_V: begin p.y0 = b0; p.u = b1; p.y1 = b2; p.v = b3; end
      ORD_Y_V_Y_U: begin p.y0 = b0; p.v = b1; p.y1 = b2; p.u = b3; end
      ORD_U_Y_V_Y: begin p.u = b0; p.y0 = b1; p.v = b2; p.y1 = b3; end
      default:     begin p.v = b0; p.y0 = b1; p.u = b2; p.y1 = b3; end
    endcase
    return p;
  endfunction
endpackage

// File: rtl/cam_sample.sv
module cam_sample
  import cam_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pclk,
  input  logic             hsync,
  input  logic             vsync,
  input  logic [PIX_W-1:0] din,
  input  logic             cfg_rise,
  input  logic             cfg_hs_high,
  input  logic             cfg_vs_high,
  output logic             s_valid,
  output logic [PIX_W-1:0] s_data,
  output logic             s_hact,
  output logic             s_vact
);
  logic             pclk_q, pclk_d, hs_q, vs_q;
  logic [PIX_W-1:0] din_q;
  logic             edge_hit;

  assign edge_hit = (pclk_q != pclk_d) && (pclk_q == cfg_rise);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pclk_q  <= 1'b0;
      pclk_d  <= 1'b0;
      hs_q    <= 1'b0;
      vs_q    <= 1'b0;
      din_q   <= '0;
      s_valid <= 1'b0;
      s_data  <= '0;
      s_hact  <= 1'b0;
      s_vact  <= 1'b0;
    end else begin
      pclk_q  <= pclk;
      pclk_d  <= pclk_q;
      hs_q    <= hsync;
      vs_q    <= vsync;
      din_q   <= din;
      s_valid <= edge_hit;
      if (edge_hit) begin
        s_data <= din_q;
        s_hact <= (hs_q == cfg_hs_high);
        s_vact <= (vs_q == cfg_vs_high);
      end
    end
  end
endmodule

// File: rtl/cam_sync_decode.sv
module cam_sync_decode
  import cam_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  input  logic [PIX_W-1:0] s_data,
  input  logic             s_hact,
  input  logic             s_vact,
  input  logic             cfg_embedded,
  input  logic             cfg_fbb,
  output logic             t_valid,
  output logic [PIX_W-1:0] t_data,
  output logic             t_act,
  output logic             t_lbeg,
  output logic             t_fbeg,
  output logic             t_field
);
  // separate-pin tracking
  logic prev_act, prev_vact;
  logic sep_act, sep_lbeg, sep_fbeg;
  // embedded-code tracking
  logic [1:0] lead_cnt;
  logic       in_line, fresh, v_last, f_code, fbb_field;
  logic       is_lead, is_code, code_v, code_h, code_f;
  logic       emb_act, emb_lbeg, emb_fbeg, field_now;
  logic [1:0] lead_nxt;

  assign sep_act  = s_hact & ~s_vact;
  assign sep_lbeg = sep_act & ~prev_act;
  assign sep_fbeg = prev_vact & ~s_vact;

  assign is_lead  = (s_data == SYNC_LEAD);
  assign is_code  = (lead_cnt == 2'd3);
  assign code_v   = s_data[XY_VBLK];
  assign code_h   = s_data[XY_EOL];
  assign code_f   = s_data[XY_FIELD];
  assign emb_act  = in_line && (lead_cnt == 2'd0) && !is_lead;
  assign emb_lbeg = emb_act & fresh;
  assign emb_fbeg = is_code & ~code_h & ~code_v & v_last;

  always_comb begin
    case (lead_cnt)
      2'd1:    lead_nxt = (s_data == SYNC_ZERO) ? 2'd2 : (is_lead ? 2'd1 : 2'd0);
      2'd2:    lead_nxt = (s_data == SYNC_ZERO) ? 2'd3 : (is_lead ? 2'd1 : 2'd0);
      default: lead_nxt = is_lead ? 2'd1 : 2'd0;
    endcase
  end

  always_comb begin
    if (cfg_fbb)      field_now = (emb_fbeg && cfg_embedded) ? ~fbb_field : fbb_field;
    else if (is_code) field_now = code_f;
    else              field_now = f_code;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_act  <= 1'b0;
      prev_vact <= 1'b0;
      lead_cnt  <= 2'd0;
      in_line   <= 1'b0;
      fresh     <= 1'b0;
      v_last    <= 1'b1;
      f_code    <= 1'b0;
      fbb_field <= 1'b1;
      t_valid   <= 1'b0;
      t_data    <= '0;
      t_act     <= 1'b0;
      t_lbeg    <= 1'b0;
      t_fbeg    <= 1'b0;
      t_field   <= 1'b0;
    end else begin
      t_valid <= s_valid;
      if (s_valid) begin
        prev_act  <= sep_act;
        prev_vact <= s_vact;
        lead_cnt  <= lead_nxt;
        if (is_lead) in_line <= 1'b0;
        if (emb_act) fresh <= 1'b0;
        if (is_code) begin
          v_last <= code_v;
          f_code <= code_f;
          if (!code_h) begin
            in_line <= ~code_v;
            fresh   <= ~code_v;
          end else begin
            in_line <= 1'b0;
          end
        end
        if (cfg_embedded && cfg_fbb && emb_fbeg) fbb_field <= ~fbb_field;
        t_data  <= s_data;
        t_act   <= cfg_embedded ? emb_act  : sep_act;
        t_lbeg  <= cfg_embedded ? emb_lbeg : sep_lbeg;
        t_fbeg  <= cfg_embedded ? emb_fbeg : sep_fbeg;
        t_field <= cfg_embedded ? field_now : 1'b0;
      end
    end
  end
endmodule

// File: rtl/cam_pack.sv
module cam_pack
  import cam_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             t_valid,
  input  logic [PIX_W-1:0] t_data,
  input  logic             t_act,
  input  logic             t_lbeg,
  input  logic             t_fbeg,
  input  logic             t_field,
  input  logic [1:0]       cfg_order,
  output logic             g_valid,
  output pair_t            g_pair,
  output logic [HW-1:0]    g_x,
  output logic [VW-1:0]    g_row,
  output logic             g_field
);
  logic [1:0]       bidx, idx;
  logic [PIX_W-1:0] hold0, hold1, hold2;
  logic [HW-1:0]    col, col_now;
  logic [VW-1:0]    row, row_now;
  logic             first_line, fl_now;

  assign idx     = t_lbeg ? 2'd0 : bidx;
  assign col_now = t_lbeg ? '0 : col;
  assign row_now = t_fbeg ? '0 : row;
  assign fl_now  = t_fbeg ? 1'b1 : first_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bidx       <= 2'd0;
      hold0      <= '0;
      hold1      <= '0;
      hold2      <= '0;
      col        <= '0;
      row        <= '0;
      first_line <= 1'b1;
      g_valid    <= 1'b0;
      g_pair     <= '0;
      g_x        <= '0;
      g_row      <= '0;
      g_field    <= 1'b0;
    end else begin
      g_valid <= 1'b0;
      if (t_valid) begin
        if (t_fbeg) begin
          row        <= '0;
          first_line <= 1'b1;
        end
        if (t_act) begin
          if (t_lbeg) begin
            row        <= fl_now ? row_now : row_now + 1'b1;
            first_line <= 1'b0;
          end
          case (idx)
            2'd0: begin hold0 <= t_data; bidx <= 2'd1; col <= col_now; end
            2'd1: begin hold1 <= t_data; bidx <= 2'd2; end
            2'd2: begin hold2 <= t_data; bidx <= 2'd3; end
            default: begin
              g_valid <= 1'b1;
              g_pair  <= reorder(byte_order_e'(cfg_order), hold0, hold1, hold2, t_data);
              g_x     <= col_now;
              g_row   <= row;
              g_field <= t_field;
              col     <= col_now + HW'(2);
              bidx    <= 2'd0;
            end
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/cam_crop.sv
module cam_crop
  import cam_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          g_valid,
  input  pair_t         g_pair,
  input  logic [HW-1:0] g_x,
  input  logic [VW-1:0] g_row,
  input  logic          g_field,
  input  logic [HW-1:0] crop_x0,
  input  logic [VW-1:0] crop_y0,
  input  logic [HW-1:0] crop_w,
  input  logic [VW-1:0] crop_h,
  output logic          c_valid,
  output pair_t         c_pair,
  output logic          c_sof,
  output logic          c_eof,
  output logic          c_field
);
  localparam int XE = HW + 1;
  localparam int YE = VW + 1;

  logic [XE-1:0] x_end, x_ext;
  logic [YE-1:0] y_end, y_ext;
  logic          in_x, in_y, last_x, last_y;

  assign x_end  = {1'b0, crop_x0} + {1'b0, crop_w};
  assign y_end  = {1'b0, crop_y0} + {1'b0, crop_h};
  assign x_ext  = {1'b0, g_x};
  assign y_ext  = {1'b0, g_row};
  assign in_x   = (g_x >= crop_x0) && (x_ext < x_end);
  assign in_y   = (g_row >= crop_y0) && (y_ext < y_end);
  assign last_x = (x_ext + XE'(2)) == x_end;
  assign last_y = (y_ext + YE'(1)) == y_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      c_valid <= 1'b0;
      c_pair  <= '0;
      c_sof   <= 1'b0;
      c_eof   <= 1'b0;
      c_field <= 1'b0;
    end else begin
      c_valid <= g_valid && in_x && in_y;
      if (g_valid) begin
        c_pair  <= g_pair;
        c_sof   <= (g_x == crop_x0) && (g_row == crop_y0);
        c_eof   <= last_x && last_y;
        c_field <= g_field;
      end
    end
  end
endmodule

// File: rtl/cam_frontend.sv
module cam_frontend
  import cam_pkg::*;
#(
  parameter int HW = 12,
  parameter int VW = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pclk,
  input  logic              hsync,
  input  logic              vsync,
  input  logic [PIX_W-1:0]  pix_data,
  input  logic              cap_enable,
  input  logic              cap_oneshot,
  input  logic              cfg_embedded,
  input  logic              cfg_fbb,
  input  logic [1:0]        cfg_order,
  input  logic              cfg_pclk_rise,
  input  logic              cfg_hs_high,
  input  logic              cfg_vs_high,
  input  logic [HW-1:0]     crop_x0,
  input  logic [VW-1:0]     crop_y0,
  input  logic [HW-1:0]     crop_w,
  input  logic [VW-1:0]     crop_h,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [PAIR_W-1:0] out_pair,
  output logic              out_sof,
  output logic              out_eof,
  output logic              out_field,
  output logic              frame_done,
  output logic              capturing
);
  logic             s_valid, s_hact, s_vact;
  logic [PIX_W-1:0] s_data;
  logic             t_valid, t_act, t_lbeg, t_fbeg, t_field;
  logic [PIX_W-1:0] t_data;
  logic             g_valid, g_field;
  pair_t            g_pair;
  logic [HW-1:0]    g_x;
  logic [VW-1:0]    g_row;
  logic             c_valid, c_sof, c_eof, c_field;
  pair_t            c_pair;
  logic             spent, frame_go, emit;

  cam_sample u_sample (
    .clk(clk), .rst_n(rst_n), .pclk(pclk), .hsync(hsync), .vsync(vsync),
    .din(pix_data), .cfg_rise(cfg_pclk_rise), .cfg_hs_high(cfg_hs_high),
    .cfg_vs_high(cfg_vs_high), .s_valid(s_valid), .s_data(s_data),
    .s_hact(s_hact), .s_vact(s_vact)
  );

  cam_sync_decode u_sync (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data),
    .s_hact(s_hact), .s_vact(s_vact), .cfg_embedded(cfg_embedded),
    .cfg_fbb(cfg_fbb), .t_valid(t_valid), .t_data(t_data), .t_act(t_act),
    .t_lbeg(t_lbeg), .t_fbeg(t_fbeg), .t_field(t_field)
  );

  cam_pack #(.HW(HW), .VW(VW)) u_pack (
    .clk(clk), .rst_n(rst_n), .t_valid(t_valid), .t_data(t_data),
    .t_act(t_act), .t_lbeg(t_lbeg), .t_fbeg(t_fbeg), .t_field(t_field),
    .cfg_order(cfg_order), .g_valid(g_valid), .g_pair(g_pair), .g_x(g_x),
    .g_row(g_row), .g_field(g_field)
  );

  cam_crop #(.HW(HW), .VW(VW)) u_crop (
    .clk(clk), .rst_n(rst_n), .g_valid(g_valid), .g_pair(g_pair),
    .g_x(g_x), .g_row(g_row), .g_field(g_field), .crop_x0(crop_x0),
    .crop_y0(crop_y0), .crop_w(crop_w), .crop_h(crop_h),
    .c_valid(c_valid), .c_pair(c_pair), .c_sof(c_sof), .c_eof(c_eof),
    .c_field(c_field)
  );

  assign frame_go = t_valid & t_fbeg;
  assign emit     = c_valid & capturing;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      capturing  <= 1'b0;
      spent      <= 1'b0;
      frame_done <= 1'b0;
      out_valid  <= 1'b0;
      out_pair   <= '0;
      out_sof    <= 1'b0;
      out_eof    <= 1'b0;
      out_field  <= 1'b0;
    end else begin
      frame_done <= emit & c_eof;
      if (!cap_enable) spent <= 1'b0;
      if (frame_go) begin
        capturing <= cap_enable & ~spent;
      end else if (emit && c_eof && cap_oneshot) begin
        capturing <= 1'b0;
        spent     <= 1'b1;
      end
      if (emit && (!out_valid || out_ready)) begin
        out_valid <= 1'b1;
        out_pair  <= c_pair;
        out_sof   <= c_sof;
        out_eof   <= c_eof;
        out_field <= c_field;
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cam_frontend_chk.sv
module cam_frontend_chk
  import cam_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cap_oneshot,
  input logic              out_valid,
  input logic              out_ready,
  input logic [PAIR_W-1:0] out_pair,
  input logic              out_sof,
  input logic              out_eof,
  input logic              frame_done,
  input logic              capturing
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !capturing && !frame_done));

  // R11
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_pair) && $stable(out_sof) && $stable(out_eof)));

  // R9
  load_needs_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> $past(capturing));

  // R10
  oneshot_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && cap_oneshot) |-> !capturing);

  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);
endmodule

bind cam_frontend cam_frontend_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cap_oneshot(cap_oneshot),
  .out_valid(out_valid), .out_ready(out_ready), .out_pair(out_pair),
  .out_sof(out_sof), .out_eof(out_eof), .frame_done(frame_done),
  .capturing(capturing)
);

// File: tb/cam_frontend_test.sv
module cam_frontend_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, pclk, hsync, vsync;
  logic [7:0]  pix_data;
  logic        cap_enable, cap_oneshot, cfg_embedded, cfg_fbb;
  logic [1:0]  cfg_order;
  logic        cfg_pclk_rise, cfg_hs_high, cfg_vs_high;
  logic [11:0] crop_x0, crop_w;
  logic [10:0] crop_y0, crop_h;
  logic        out_valid, out_ready, out_sof, out_eof, out_field;
  logic [31:0] out_pair;
  logic        frame_done, capturing;

  cam_frontend uut (
    .clk(clk), .rst_n(rst_n), .pclk(pclk), .hsync(hsync), .vsync(vsync),
    .pix_data(pix_data), .cap_enable(cap_enable), .cap_oneshot(cap_oneshot),
    .cfg_embedded(cfg_embedded), .cfg_fbb(cfg_fbb), .cfg_order(cfg_order),
    .cfg_pclk_rise(cfg_pclk_rise), .cfg_hs_high(cfg_hs_high),
    .cfg_vs_high(cfg_vs_high), .crop_x0(crop_x0), .crop_y0(crop_y0),
    .crop_w(crop_w), .crop_h(crop_h), .out_valid(out_valid),
    .out_ready(out_ready), .out_pair(out_pair), .out_sof(out_sof),
    .out_eof(out_eof), .out_field(out_field), .frame_done(frame_done),
    .capturing(capturing)
  );

  int n_chk = 0;
  int n_fail = 0;

  // monitor of accepted pairs
  logic [31:0] got_pair [0:255];
  logic        got_sof  [0:255];
  logic        got_eof  [0:255];
  logic        got_fld  [0:255];
  int n_got  = 0;
  int n_done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (out_valid && out_ready && n_got < 256) begin
        got_pair[n_got] <= out_pair;
        got_sof[n_got]  <= out_sof;
        got_eof[n_got]  <= out_eof;
        got_fld[n_got]  <= out_field;
        n_got <= n_got + 1;
      end
      if (frame_done) n_done <= n_done + 1;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pb(input int line, input int i);
    return 8'(line * 32 + i + 1);
  endfunction

  // expected packing: {V, Y1, U, Y0}
  function automatic logic [31:0] exp_pair(input int line, input int x, input int ord);
    logic [7:0] b0, b1, b2, b3, y0, u, y1, v;
    b0 = pb(line, 2*x); b1 = pb(line, 2*x+1); b2 = pb(line, 2*x+2); b3 = pb(line, 2*x+3);
    case (ord)
      0: begin y0 = b0; u = b1; y1 = b2; v = b3; end
      1: begin y0 = b0; v = b1; y1 = b2; u = b3; end
      2: begin u = b0; y0 = b1; v = b2; y1 = b3; end
      default: begin v = b0; y0 = b1; u = b2; y1 = b3; end
    endcase
    return {v, y1, u, y0};
  endfunction

  // one sensor byte: decoy on the non-latching edge, real byte on the latching edge
  task automatic send_byte(input logic [7:0] d, input bit h_act, input bit v_act);
    @(posedge clk);
    pclk     <= ~cfg_pclk_rise;
    pix_data <= 8'h5A;
    repeat (2) @(posedge clk);
    pclk     <= cfg_pclk_rise;
    pix_data <= d;
    hsync    <= h_act ? cfg_hs_high : ~cfg_hs_high;
    vsync    <= v_act ? cfg_vs_high : ~cfg_vs_high;
    repeat (2) @(posedge clk);
  endtask

  task automatic sep_frame();
    for (int k = 0; k < 3; k++) send_byte(8'h00, 1'b0, 1'b1);
    for (int line = 0; line < 4; line++) begin
      for (int k = 0; k < 2; k++) send_byte(8'h00, 1'b0, 1'b0);
      for (int i = 0; i < 16; i++) send_byte(pb(line, i), 1'b1, 1'b0);
      for (int k = 0; k < 2; k++) send_byte(8'h00, 1'b0, 1'b0);
    end
    for (int k = 0; k < 2; k++) send_byte(8'h00, 1'b0, 1'b1);
    repeat (10) @(posedge clk);
  endtask

  task automatic send_code(input logic [7:0] xy);
    send_byte(8'hFF, 1'b0, 1'b0);
    send_byte(8'h00, 1'b0, 1'b0);
    send_byte(8'h00, 1'b0, 1'b0);
    send_byte(xy, 1'b0, 1'b0);
  endtask

  task automatic emb_frame(input bit f);
    logic [7:0] fb;
    fb = f ? 8'h40 : 8'h00;
    send_code(8'hA0 | fb);
    for (int k = 0; k < 4; k++) send_byte(8'h10, 1'b0, 1'b0);
    send_code(8'hB0 | fb);
    for (int line = 0; line < 4; line++) begin
      send_code(8'h80 | fb);
      for (int i = 0; i < 16; i++) send_byte(pb(line, i), 1'b0, 1'b0);
      send_code(8'h90 | fb);
    end
    send_code(8'hA0 | fb);
    for (int k = 0; k < 4; k++) send_byte(8'h10, 1'b0, 1'b0);
    send_code(8'hB0 | fb);
    repeat (10) @(posedge clk);
  endtask

  // window: x0=2 w=4 y0=1 h=2 -> lines 1,2 and x 2,4
  task automatic verify_frame(input int base, input int ord, input bit fld, input string tag);
    int k;
    check(n_got - base == 4, {tag, " R6 pair count"}, 32'(n_got - base), 32'd4);
    k = 0;
    for (int line = 1; line <= 2; line++) begin
      for (int x = 2; x <= 4; x += 2) begin
        if (base + k < n_got) begin
          check(got_pair[base+k] === exp_pair(line, x, ord), {tag, " R5 R12 pair data"},
                got_pair[base+k], exp_pair(line, x, ord));
          check(got_sof[base+k] === (k == 0), {tag, " R7 sof"},
                32'(got_sof[base+k]), 32'(k == 0));
          check(got_eof[base+k] === (k == 3), {tag, " R7 eof"},
                32'(got_eof[base+k]), 32'(k == 3));
          check(got_fld[base+k] === fld, {tag, " R8 field"},
                32'(got_fld[base+k]), 32'(fld));
        end
        k++;
      end
    end
  endtask

  task automatic test_reset();
    @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", 32'(out_valid), 32'd0);
    check(capturing == 1'b0, "R1 capturing", 32'(capturing), 32'd0);
    check(frame_done == 1'b0, "R1 frame_done", 32'(frame_done), 32'd0);
  endtask

  task automatic test_orders();
    int base, d0;
    cap_enable = 1'b1;
    for (int ord = 0; ord < 4; ord++) begin
      cfg_order = 2'(ord);
      base = n_got; d0 = n_done;
      sep_frame();
      verify_frame(base, ord, 1'b0, "R3 separate sync");
      check(n_done - d0 == 1, "R10 frame_done count", 32'(n_done - d0), 32'd1);
      check(capturing == 1'b1, "R9 capturing on", 32'(capturing), 32'd1);
    end
  endtask

  task automatic test_polarity_edge();
    int base;
    cfg_order = 2'd0;
    cfg_hs_high = 1'b0; cfg_vs_high = 1'b0; cfg_pclk_rise = 1'b0;
    pclk = 1'b0; hsync = 1'b1; vsync = 1'b1;
    repeat (4) @(posedge clk);
    base = n_got;
    sep_frame();
    verify_frame(base, 0, 1'b0, "R2 R3 low polarity falling edge");
    cfg_hs_high = 1'b1; cfg_vs_high = 1'b1; cfg_pclk_rise = 1'b1;
    pclk = 1'b0; hsync = 1'b0; vsync = 1'b0;
    repeat (4) @(posedge clk);
  endtask

  task automatic test_embedded();
    int base;
    cfg_embedded = 1'b1; cfg_order = 2'd2;
    base = n_got;
    emb_frame(1'b1);
    verify_frame(base, 2, 1'b1, "R4 embedded field1");
    base = n_got;
    emb_frame(1'b0);
    verify_frame(base, 2, 1'b0, "R4 embedded field0");
  endtask

  task automatic test_fbb();
    int base;
    cfg_fbb = 1'b1;
    base = n_got;
    emb_frame(1'b1);
    verify_frame(base, 2, 1'b0, "R8 fbb first frame");
    base = n_got;
    emb_frame(1'b1);
    verify_frame(base, 2, 1'b1, "R8 fbb second frame");
    cfg_fbb = 1'b0; cfg_embedded = 1'b0;
  endtask

  task automatic test_arm();
    int base;
    cap_enable = 1'b0;
    base = n_got;
    sep_frame();
    check(n_got == base, "R9 disabled frame pairs", 32'(n_got - base), 32'd0);
    check(capturing == 1'b0, "R9 capturing off", 32'(capturing), 32'd0);
  endtask

  task automatic test_oneshot();
    int base, d0;
    cap_enable = 1'b1; cap_oneshot = 1'b1; cfg_order = 2'd1;
    base = n_got; d0 = n_done;
    sep_frame();
    check(capturing == 1'b0, "R10 stop after frame", 32'(capturing), 32'd0);
    sep_frame();
    verify_frame(base, 1, 1'b0, "R10 one shot");
    check(n_done - d0 == 1, "R10 one done pulse", 32'(n_done - d0), 32'd1);
    cap_oneshot = 1'b0; cap_enable = 1'b0;
    repeat (3) @(posedge clk);
    cap_enable = 1'b1;
  endtask

  task automatic test_backpressure();
    int base, d0;
    cfg_order = 2'd3;
    out_ready = 1'b0;
    base = n_got; d0 = n_done;
    sep_frame();
    @(negedge clk);
    check(out_valid == 1'b1, "R11 held valid", 32'(out_valid), 32'd1);
    check(out_pair === exp_pair(1, 2, 3), "R11 held first pair", out_pair, exp_pair(1, 2, 3));
    check(out_sof == 1'b1, "R11 held sof", 32'(out_sof), 32'd1);
    check(n_done - d0 == 1, "R10 done under stall", 32'(n_done - d0), 32'd1);
    out_ready = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(n_got - base == 1, "R11 later pairs dropped", 32'(n_got - base), 32'd1);
    check(out_valid == 1'b0, "R11 drained", 32'(out_valid), 32'd0);
  endtask

  initial begin
    rst_n = 1'b0; pclk = 1'b0; hsync = 1'b0; vsync = 1'b0; pix_data = 8'h00;
    cap_enable = 1'b0; cap_oneshot = 1'b0; cfg_embedded = 1'b0; cfg_fbb = 1'b0;
    cfg_order = 2'd0; cfg_pclk_rise = 1'b1; cfg_hs_high = 1'b1; cfg_vs_high = 1'b1;
    crop_x0 = 12'd2; crop_w = 12'd4; crop_y0 = 11'd1; crop_h = 11'd2;
    out_ready = 1'b1;
    repeat (3) @(posedge clk);
    test_reset();
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    test_reset();
    test_orders();
    test_polarity_edge();
    test_embedded();
    test_fbb();
    test_arm();
    test_oneshot();
    test_backpressure();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule